// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Unit

This block chooses the two ALU operands for the execute stage of a five-stage in-order integer pipeline. For each source register number of the instruction in execute, it looks for a pending write to that register in the two older stages. The older stages are the execute/memory stage and the memory/writeback stage. When one of them will write that register, its result goes straight to the ALU input. Otherwise the value read from the register file is used.

The unit has no state. Register numbers, write-enable bits and data from the surrounding pipeline registers come in as plain ports. The 2-bit select codes and the two chosen operands leave in the same cycle.

Register zero always reads as zero, so a result aimed at it is never bypassed. An instruction that does not write a register, such as a store or a branch, never supplies a bypass. A read that matches the register being written back in the same cycle needs no path here, because the register file writes in the first half of the cycle and reads in the second.

Top module: `op_bypass_unit`

## Requirements
- R1: Each select output is 2 bits. 2'b00 chooses the register file value, 2'b10 chooses the execute/memory result, and 2'b01 chooses the memory/writeback result. The value 2'b11 is never driven.
- R2: `sel_a_o` is 2'b10 when all three hold: `exm_wr_en_i` is high, `exm_dst_i` is non-zero, and `exm_dst_i` equals `src_a_idx_i`.
- R3: `sel_b_o` is 2'b10 under the same three conditions, tested against `src_b_idx_i`.
- R4: A select is 2'b01 when all three hold: `mwb_wr_en_i` is high, `mwb_dst_i` is non-zero, and `mwb_dst_i` equals that operand's source index. This applies only when the execute/memory condition for that operand is false.
- R5: When both stages qualify for the same source, the select is 2'b10, because the newer result wins.
- R6: A destination of register zero never causes a bypass. The select is 2'b00 and the operand equals the register file value.
- R7: A stage whose write enable is low never causes a bypass, even when its destination matches.
- R8: Each operand output equals the data chosen by its select: `rf_*_data_i` for 00, `exm_res_i` for 10, and `mwb_res_i` for 01.
- R9: The unit is combinational. Selects and operands reflect the current inputs with no cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_idx_i | input | 5 | First source register number of the execute-stage instruction |
| src_b_idx_i | input | 5 | Second source register number of the execute-stage instruction |
| rf_a_data_i | input | 32 | Register file value for the first source |
| rf_b_data_i | input | 32 | Register file value for the second source |
| exm_wr_en_i | input | 1 | Execute/memory instruction writes a register |
| exm_dst_i | input | 5 | Execute/memory destination register number |
| exm_res_i | input | 32 | Execute/memory result |
| mwb_wr_en_i | input | 1 | Memory/writeback instruction writes a register |
| mwb_dst_i | input | 5 | Memory/writeback destination register number |
| mwb_res_i | input | 32 | Memory/writeback value |
| sel_a_o | output | 2 | Select code for operand A |
| sel_b_o | output | 2 | Select code for operand B |
| opnd_a_o | output | 32 | Chosen ALU operand A |
| opnd_b_o | output | 32 | Chosen ALU operand B |

## Verification
Some checks run on every evaluation:
- the select never takes the unused code (R1);
- a qualifying execute/memory match always yields 10 (R2, R3), whatever the older stage holds, which covers the priority rule (R5);
- a zero destination or a cleared write enable is never the source of a bypass (R6, R7);
- each operand matches the data its select names (R8).

Other behaviour needs the bench's directed scenarios:
- the priority outcome on accumulate chains;
- the memory/writeback path taking over only when the newer stage misses (R4);
- the same-cycle response to changed inputs (R9).

These scenarios depend on chosen register collisions that random stimulus rarely produces.

// File: rtl/op_bypass_pkg.sv
package op_bypass_pkg;
  localparam int unsigned REG_AW = 5;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_RF  = 2'b00,
    SEL_MWB = 2'b01,
    SEL_EXM = 2'b10
  } byp_sel_e;
endpackage

// File: rtl/byp_match.sv
module byp_match
  import op_bypass_pkg::*;
#(
  parameter int unsigned AW = REG_AW
) (
  input  logic [AW-1:0]    src_idx_i,
  input  logic             exm_wr_en_i,
  input  logic [AW-1:0]    exm_dst_i,
  input  logic             mwb_wr_en_i,
  input  logic [AW-1:0]    mwb_dst_i,
  output logic [SEL_W-1:0] sel_o
);
  logic exm_hit, mwb_hit;

  assign exm_hit = exm_wr_en_i && (exm_dst_i != '0) && (exm_dst_i == src_idx_i);
  assign mwb_hit = mwb_wr_en_i && (mwb_dst_i != '0) && (mwb_dst_i == src_idx_i);

  // newer stage first
  always_comb begin
    if (exm_hit)      sel_o = SEL_EXM;
    else if (mwb_hit) sel_o = SEL_MWB;
    else              sel_o = SEL_RF;
  end

  always_comb begin
    // R1
    sel_never_11_chk: assert (sel_o != 2'b11);
    // R5
    exm_priority_chk: assert (!(exm_wr_en_i && exm_dst_i != '0 && exm_dst_i == src_idx_i)
                              || sel_o == SEL_EXM);
    // R6
    zero_dst_chk: assert (!(exm_dst_i == '0 && mwb_dst_i == '0) || sel_o == SEL_RF);
    // R7
    no_wr_chk: assert (exm_wr_en_i || mwb_wr_en_i || sel_o == SEL_RF);
  end
endmodule

// File: rtl/byp_mux.sv
module byp_mux
  import op_bypass_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [DW-1:0]    rf_data_i,
  input  logic [DW-1:0]    exm_res_i,
  input  logic [DW-1:0]    mwb_res_i,
  output logic [DW-1:0]    opnd_o
);
  // unused code 11 falls back to register file
  always_comb begin
    unique case (sel_i)
      SEL_EXM: opnd_o = exm_res_i;
      SEL_MWB: opnd_o = mwb_res_i;
      default: opnd_o = rf_data_i;
    endcase
  end

  always_comb begin
    // R8
    mux_exm_chk: assert (sel_i != SEL_EXM || opnd_o == exm_res_i);
    // R8
    mux_mwb_chk: assert (sel_i != SEL_MWB || opnd_o == mwb_res_i);
  end
endmodule

// File: rtl/op_bypass_unit.sv
module op_bypass_unit
  import op_bypass_pkg::*;
(
  input  logic [REG_AW-1:0] src_a_idx_i,
  input  logic [REG_AW-1:0] src_b_idx_i,
  input  logic [DATA_W-1:0] rf_a_data_i,
  input  logic [DATA_W-1:0] rf_b_data_i,
  input  logic              exm_wr_en_i,
  input  logic [REG_AW-1:0] exm_dst_i,
  input  logic [DATA_W-1:0] exm_res_i,
  input  logic              mwb_wr_en_i,
  input  logic [REG_AW-1:0] mwb_dst_i,
  input  logic [DATA_W-1:0] mwb_res_i,
  output logic [SEL_W-1:0]  sel_a_o,
  output logic [SEL_W-1:0]  sel_b_o,
  output logic [DATA_W-1:0] opnd_a_o,
  output logic [DATA_W-1:0] opnd_b_o
);
  localparam int unsigned NUM_SRC = 2;

  logic [REG_AW-1:0] src_idx [NUM_SRC];
  logic [DATA_W-1:0] rf_data [NUM_SRC];
  logic [SEL_W-1:0]  sel     [NUM_SRC];
  logic [DATA_W-1:0] opnd    [NUM_SRC];

  assign src_idx[0] = src_a_idx_i;
  assign src_idx[1] = src_b_idx_i;
  assign rf_data[0] = rf_a_data_i;
  assign rf_data[1] = rf_b_data_i;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    byp_match #(.AW(REG_AW)) u_match (
      .src_idx_i   (src_idx[g]),
      .exm_wr_en_i (exm_wr_en_i),
      .exm_dst_i   (exm_dst_i),
      .mwb_wr_en_i (mwb_wr_en_i),
      .mwb_dst_i   (mwb_dst_i),
      .sel_o       (sel[g])
    );

    byp_mux #(.DW(DATA_W)) u_mux (
      .sel_i     (sel[g]),
      .rf_data_i (rf_data[g]),
      .exm_res_i (exm_res_i),
      .mwb_res_i (mwb_res_i),
      .opnd_o    (opnd[g])
    );
  end

  assign sel_a_o  = sel[0];
  assign sel_b_o  = sel[1];
  assign opnd_a_o = opnd[0];
  assign opnd_b_o = opnd[1];

  always_comb begin
    // R2
    a_exm_chk: assert (!(exm_wr_en_i && exm_dst_i != '0 && exm_dst_i == src_a_idx_i)
                       || opnd_a_o == exm_res_i);
    // R3
    b_exm_chk: assert (!(exm_wr_en_i && exm_dst_i != '0 && exm_dst_i == src_b_idx_i)
                       || opnd_b_o == exm_res_i);
  end
endmodule

// File: tb/op_bypass_unit_bench.sv
module op_bypass_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [4:0]  src_a, src_b, exm_dst, mwb_dst;
  logic [31:0] rf_a, rf_b, exm_res, mwb_res;
  logic        exm_wr, mwb_wr;
  logic [1:0]  sel_a, sel_b;
  logic [31:0] opnd_a, opnd_b;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  op_bypass_unit u_op_bypass_unit (
    .src_a_idx_i (src_a), .src_b_idx_i (src_b),
    .rf_a_data_i (rf_a),  .rf_b_data_i (rf_b),
    .exm_wr_en_i (exm_wr), .exm_dst_i (exm_dst), .exm_res_i (exm_res),
    .mwb_wr_en_i (mwb_wr), .mwb_dst_i (mwb_dst), .mwb_res_i (mwb_res),
    .sel_a_o (sel_a), .sel_b_o (sel_b), .opnd_a_o (opnd_a), .opnd_b_o (opnd_b)
  );

  function automatic logic [1:0] ref_sel(input logic [4:0] s);
    if (exm_wr && exm_dst != 0 && exm_dst == s) return 2'b10;
    if (mwb_wr && mwb_dst != 0 && mwb_dst == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [31:0] ref_opnd(input logic [1:0] s, input logic [31:0] rf);
    if (s == 2'b10) return exm_res;
    if (s == 2'b01) return mwb_res;
    return rf;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive on posedge, compare at negedge
  task automatic step(input string tag,
                      input logic [4:0] sa, input logic [4:0] sb,
                      input logic ew, input logic [4:0] ed,
                      input logic mw, input logic [4:0] md);
    @(posedge clk);
    src_a = sa; src_b = sb; exm_wr = ew; exm_dst = ed; mwb_wr = mw; mwb_dst = md;
    rf_a = 32'hA000_0000 | 32'(sa); rf_b = 32'hB000_0000 | 32'(sb);
    exm_res = 32'hE000_0000 | 32'(ed); mwb_res = 32'h5000_0000 | 32'(md);
    @(negedge clk);
    begin
      logic [1:0] ea, eb;
      ea = ref_sel(src_a);
      eb = ref_sel(src_b);
      chk({tag, " sel_a"}, 32'(sel_a), 32'(ea));
      chk({tag, " sel_b"}, 32'(sel_b), 32'(eb));
      chk({tag, " opnd_a"}, opnd_a, ref_opnd(ea, rf_a));
      chk({tag, " opnd_b"}, opnd_b, ref_opnd(eb, rf_b));
    end
  endtask

  initial begin
    src_a = 0; src_b = 0; exm_wr = 0; exm_dst = 0; mwb_wr = 0; mwb_dst = 0;
    rf_a = 0; rf_b = 0; exm_res = 0; mwb_res = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset sel_a", 32'(sel_a), 32'd0);
    chk("R1 reset sel_b", 32'(sel_b), 32'd0);
    step("R1 no hazard",        5'd3, 5'd4, 1'b1, 5'd7, 1'b1, 5'd8);
    step("R2 exm on A",         5'd6, 5'd4, 1'b1, 5'd6, 1'b0, 5'd0);
    step("R3 exm on B",         5'd3, 5'd9, 1'b1, 5'd9, 1'b1, 5'd2);
    step("R3 exm on both",      5'd5, 5'd5, 1'b1, 5'd5, 1'b0, 5'd1);
    step("R4 mwb on A",         5'd11, 5'd4, 1'b1, 5'd7, 1'b1, 5'd11);
    step("R4 mwb on B",         5'd3, 5'd12, 1'b0, 5'd12, 1'b1, 5'd12);
    step("R5 accumulate A",     5'd1, 5'd2, 1'b1, 5'd1, 1'b1, 5'd1);
    step("R5 accumulate B",     5'd2, 5'd1, 1'b1, 5'd1, 1'b1, 5'd1);
    step("R5 split stages",     5'd1, 5'd2, 1'b1, 5'd2, 1'b1, 5'd1);
    step("R6 zero dst exm",     5'd0, 5'd0, 1'b1, 5'd0, 1'b0, 5'd3);
    step("R6 zero dst exm,mwb", 5'd4, 5'd0, 1'b1, 5'd0, 1'b1, 5'd4);
    step("R6 zero dst both",    5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0);
    step("R7 exm wr low",       5'd8, 5'd8, 1'b0, 5'd8, 1'b0, 5'd8);
    step("R7 exm wr low mwb",   5'd8, 5'd9, 1'b0, 5'd8, 1'b1, 5'd9);
    step("R9 back-to-back",     5'd31, 5'd30, 1'b1, 5'd31, 1'b1, 5'd30);
    for (int i = 0; i < 300; i++) begin
      step("R8 random",
           5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
           1'($urandom), 5'($urandom_range(0, 3)),
           1'($urandom), 5'($urandom_range(0, 3)));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule